// File: doc/BRIEF.md
# Type-Guarded Tagged Arithmetic Unit

This execute-stage unit serves a small in-order core that runs dynamically typed scripts. Each source operand arrives as a value with an 8-bit type tag and a one-bit number-kind flag (0 = integer, 1 = float). The unit computes a tagged add, subtract or multiply. In the same stage it checks whether both operands have the fast-path type: the same tag on both sides, and both flagged integer. Both results are registered together, so the check costs no extra cycle.

When the guard passes, the unit issues a writeback of the wrapped integer result to the destination index. The writeback carries the shared tag and the integer flag. When the guard fails, the unit issues no writeback. Instead it raises a one-cycle redirect that carries the slow-path address held in a programmable handler register. A script engine loads its own slow-path entry point into that register through a simple write port. Floating-point arithmetic is not computed here. Float operands always take the slow path.

Top module: `tgu_tagged_alu`

## Requirements
- R1: After synchronous reset, `wb_valid` and `redirect_valid` are 0, and `hdl_value` equals the `HDL_RESET` parameter.
- R2: Opcode 2'b00 (tagged add) on a fast-path pair gives `wb_val` = (a + b) mod 2^DATA_W on the clock edge after issue.
- R3: Opcode 2'b01 (tagged subtract) on a fast-path pair gives `wb_val` = (a − b) mod 2^DATA_W, with borrow discarded.
- R4: Opcode 2'b10 (tagged multiply) on a fast-path pair gives `wb_val` equal to the low DATA_W bits of a × b.
- R5: A pair is fast-path only when `a_tag` == `b_tag` and `a_fi` == 0 and `b_fi` == 0. In that case `wb_valid` is 1 for one cycle, with `wb_tag` = the shared tag, `wb_fi` = 0 and `wb_idx` = `dst_idx`.
- R6: An issue with a legal opcode whose pair is not fast-path (tags differ, or either flag is 1) gives `wb_valid` = 0 and `redirect_valid` = 1 for one cycle, with `redirect_pc` = the handler register contents. Writeback and redirect are never high together.
- R7: `hdl_we` loads `hdl_wdata` into the handler register on the next edge, and it is visible on `hdl_value` from then on. A mismatch issued in the same cycle as a write redirects to the value held before that write.
- R8: Opcode 2'b11 is reserved. Issuing it raises neither writeback nor redirect.
- R9: With `issue_valid` low, both `wb_valid` and `redirect_valid` are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 reserved |
| a_val | input | DATA_W | Operand A value |
| a_tag | input | TAG_W | Operand A type tag |
| a_fi | input | 1 | Operand A kind flag (0 integer, 1 float) |
| b_val | input | DATA_W | Operand B value |
| b_tag | input | TAG_W | Operand B type tag |
| b_fi | input | 1 | Operand B kind flag |
| dst_idx | input | REG_AW | Destination register index |
| hdl_we | input | 1 | Handler register write enable |
| hdl_wdata | input | PC_W | New handler address |
| wb_valid | output | 1 | Writeback request (one cycle) |
| wb_idx | output | REG_AW | Writeback destination index |
| wb_val | output | DATA_W | Writeback value |
| wb_tag | output | TAG_W | Writeback type tag |
| wb_fi | output | 1 | Writeback kind flag |
| redirect_valid | output | 1 | Type mispredict pulse (one cycle) |
| redirect_pc | output | PC_W | Slow-path target address |
| hdl_value | output | PC_W | Current handler register contents |

## Verification
The bench builds the unit with 32-bit data, 8-bit tags, 32-bit addresses, 5-bit register indices and a nonzero handler reset value. The 32-bit width lets the bench drive sums, borrows and products that overflow, and check the wrap directly. The 8-bit tags allow tag pairs that differ in a single high bit. The nonzero reset value makes a redirect taken before any write distinguishable from one that reads zero.

// File: rtl/tgu_pkg.sv
package tgu_pkg;

    typedef enum logic [1:0] {
        OP_XADD = 2'b00,
        OP_XSUB = 2'b01,
        OP_XMUL = 2'b10,
        OP_RSVD = 2'b11
    } tgu_op_e;

    localparam logic KIND_INT = 1'b0;
    localparam logic KIND_FLT = 1'b1;

    typedef struct packed {
        logic fast;
        logic kind;
    } guard_res_t;

    function automatic logic op_is_legal(input tgu_op_e op);
        return op != OP_RSVD;
    endfunction

endpackage

// File: rtl/tgu_type_guard.sv
module tgu_type_guard
    import tgu_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] a_tag,
    input  logic             a_kind,
    input  logic [TAG_W-1:0] b_tag,
    input  logic             b_kind,
    output guard_res_t       res,
    output logic [TAG_W-1:0] res_tag
);
    logic same_tag;
    logic both_int;

    always_comb begin
        same_tag = (a_tag == b_tag);
        both_int = (a_kind == KIND_INT) && (b_kind == KIND_INT);
        res.fast = same_tag && both_int;
        res.kind = KIND_INT;
        res_tag  = a_tag;
    end
endmodule

// File: rtl/tgu_int_alu.sv
module tgu_int_alu
    import tgu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tgu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] dif_w;
    logic [DATA_W-1:0] prd_w;

    always_comb begin
        sum_w = a + b;
        dif_w = a - b;
        prd_w = a * b;
        unique case (op)
            OP_XADD: y = sum_w;
            OP_XSUB: y = dif_w;
            OP_XMUL: y = prd_w;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tgu_hdl_reg.sv
module tgu_hdl_reg #(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [PC_W-1:0] wdata,
    output logic [PC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RESET_VAL;
        else if (we) q <= wdata;
    end

    a_r7_hdl_load: assert property (@(posedge clk) disable iff (rst)
        $past(we && !rst) |-> q == $past(wdata));

    a_r7_hdl_hold: assert property (@(posedge clk) disable iff (rst)
        $past(!we && !rst) |-> $stable(q));
endmodule

// File: rtl/tgu_tagged_alu.sv
module tgu_tagged_alu
    import tgu_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              TAG_W     = 8,
    parameter int              PC_W      = 32,
    parameter int              REG_AW    = 5,
    parameter logic [PC_W-1:0] HDL_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [1:0]        issue_op,
    input  logic [DATA_W-1:0] a_val,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic              a_fi,
    input  logic [DATA_W-1:0] b_val,
    input  logic [TAG_W-1:0]  b_tag,
    input  logic              b_fi,
    input  logic [REG_AW-1:0] dst_idx,
    input  logic              hdl_we,
    input  logic [PC_W-1:0]   hdl_wdata,
    output logic              wb_valid,
    output logic [REG_AW-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_val,
    output logic [TAG_W-1:0]  wb_tag,
    output logic              wb_fi,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [PC_W-1:0]   hdl_value
);
    tgu_op_e           op_e;
    guard_res_t        guard;
    logic [TAG_W-1:0]  guard_tag;
    logic [DATA_W-1:0] alu_y;
    logic              fire;

    assign op_e = tgu_op_e'(issue_op);

    tgu_type_guard #(.TAG_W(TAG_W)) u_guard (
        .a_tag   (a_tag),
        .a_kind  (a_fi),
        .b_tag   (b_tag),
        .b_kind  (b_fi),
        .res     (guard),
        .res_tag (guard_tag)
    );

    tgu_int_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op_e),
        .a  (a_val),
        .b  (b_val),
        .y  (alu_y)
    );

    tgu_hdl_reg #(.PC_W(PC_W), .RESET_VAL(HDL_RESET)) u_hdl (
        .clk   (clk),
        .rst   (rst),
        .we    (hdl_we),
        .wdata (hdl_wdata),
        .q     (hdl_value)
    );

    assign fire = issue_valid && op_is_legal(op_e);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid       <= 1'b0;
            wb_idx         <= '0;
            wb_val         <= '0;
            wb_tag         <= '0;
            wb_fi          <= KIND_INT;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            wb_valid       <= fire && guard.fast;
            redirect_valid <= fire && !guard.fast;
            wb_idx         <= dst_idx;
            wb_val         <= alu_y;
            wb_tag         <= guard_tag;
            wb_fi          <= guard.kind;
            redirect_pc    <= hdl_value;
        end
    end

    // R6: guard outcome is exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid && redirect_valid));

    // R9: outputs only follow an issue
    a_r9_wb_needs_issue: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(issue_valid));

    a_r9_redirect_needs_issue: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> $past(issue_valid));

    // R5: writeback always integer-flagged
    a_r5_wb_int: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> wb_fi == KIND_INT);

    // R8: reserved opcode is silent
    a_r8_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        $past(issue_valid && issue_op == 2'b11 && !rst) |-> !wb_valid && !redirect_valid);

    // R7: redirect target is the handler value before the issue edge
    a_r7_redirect_target: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> redirect_pc == $past(hdl_value));
endmodule

// File: tb/test_tgu_tagged_alu.sv
module test_tgu_tagged_alu;
    localparam int          DW  = 32;
    localparam int          TW  = 8;
    localparam int          PW  = 32;
    localparam int          AW  = 5;
    localparam logic [31:0] HRST = 32'h0000_0F00;

    logic          clk = 1'b0;
    logic          rst;
    logic          issue_valid;
    logic [1:0]    issue_op;
    logic [DW-1:0] a_val, b_val;
    logic [TW-1:0] a_tag, b_tag;
    logic          a_fi, b_fi;
    logic [AW-1:0] dst_idx;
    logic          hdl_we;
    logic [PW-1:0] hdl_wdata;
    logic          wb_valid, wb_fi, redirect_valid;
    logic [AW-1:0] wb_idx;
    logic [DW-1:0] wb_val;
    logic [TW-1:0] wb_tag;
    logic [PW-1:0] redirect_pc, hdl_value;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tgu_tagged_alu #(.DATA_W(DW), .TAG_W(TW), .PC_W(PW), .REG_AW(AW), .HDL_RESET(HRST)) i_tgu_tagged_alu (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .a_val(a_val), .a_tag(a_tag), .a_fi(a_fi),
        .b_val(b_val), .b_tag(b_tag), .b_fi(b_fi),
        .dst_idx(dst_idx), .hdl_we(hdl_we), .hdl_wdata(hdl_wdata),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_val(wb_val), .wb_tag(wb_tag), .wb_fi(wb_fi),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .hdl_value(hdl_value)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, release, then sample at the following negedge
    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [7:0] ta, input logic fa,
                         input logic [31:0] b, input logic [7:0] tb, input logic fb, input logic [4:0] d);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op;
        a_val = a; a_tag = ta; a_fi = fa;
        b_val = b; b_tag = tb; b_fi = fb;
        dst_idx = d;
        @(negedge clk);
        issue_valid = 1'b0;
        hdl_we = 1'b0;
    endtask

    task automatic expect_wb(input string req, input logic [31:0] v, input logic [7:0] t, input logic [4:0] d);
        check({req, " wb_valid"}, 64'(wb_valid), 64'd1);
        check({req, " redirect_valid"}, 64'(redirect_valid), 64'd0);
        check({req, " wb_val"}, 64'(wb_val), 64'(v));
        check({req, " wb_tag"}, 64'(wb_tag), 64'(t));
        check({req, " wb_fi"}, 64'(wb_fi), 64'd0);
        check({req, " wb_idx"}, 64'(wb_idx), 64'(d));
    endtask

    task automatic expect_redirect(input string req, input logic [31:0] pc);
        check({req, " wb_valid"}, 64'(wb_valid), 64'd0);
        check({req, " redirect_valid"}, 64'(redirect_valid), 64'd1);
        check({req, " redirect_pc"}, 64'(redirect_pc), 64'(pc));
    endtask

    task automatic t_reset;
        rst = 1'b1; issue_valid = 1'b0; issue_op = 2'b00;
        a_val = '0; b_val = '0; a_tag = '0; b_tag = '0; a_fi = 1'b0; b_fi = 1'b0;
        dst_idx = '0; hdl_we = 1'b0; hdl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wb_valid", 64'(wb_valid), 64'd0);
        check("R1 redirect_valid", 64'(redirect_valid), 64'd0);
        check("R1 hdl_value", 64'(hdl_value), 64'(HRST));
    endtask

    task automatic t_add;
        issue(2'b00, 32'd7, 8'h11, 1'b0, 32'd5, 8'h11, 1'b0, 5'd3);
        expect_wb("R2 add", 32'd12, 8'h11, 5'd3);
        issue(2'b00, 32'hFFFF_FFFE, 8'h22, 1'b0, 32'd5, 8'h22, 1'b0, 5'd9);
        expect_wb("R2 add wrap", 32'd3, 8'h22, 5'd9);
    endtask

    task automatic t_sub;
        issue(2'b01, 32'd100, 8'h05, 1'b0, 32'd40, 8'h05, 1'b0, 5'd1);
        expect_wb("R3 sub", 32'd60, 8'h05, 5'd1);
        issue(2'b01, 32'd2, 8'h05, 1'b0, 32'd3, 8'h05, 1'b0, 5'd31);
        expect_wb("R3 sub borrow", 32'hFFFF_FFFF, 8'h05, 5'd31);
    endtask

    task automatic t_mul;
        issue(2'b10, 32'd1234, 8'h7F, 1'b0, 32'd1000, 8'h7F, 1'b0, 5'd4);
        expect_wb("R4 mul", 32'd1234000, 8'h7F, 5'd4);
        issue(2'b10, 32'h0001_0003, 8'h80, 1'b0, 32'h0002_0005, 8'h80, 1'b0, 5'd5);
        expect_wb("R4 mul wrap", 32'h000B_000F, 8'h80, 5'd5);
    endtask

    task automatic t_mismatch;
        issue(2'b00, 32'd1, 8'h01, 1'b0, 32'd2, 8'h81, 1'b0, 5'd6);
        expect_redirect("R6 tag high bit", HRST);
        issue(2'b01, 32'd1, 8'h01, 1'b1, 32'd2, 8'h01, 1'b0, 5'd6);
        expect_redirect("R6 a float", HRST);
        issue(2'b10, 32'd1, 8'h01, 1'b0, 32'd2, 8'h01, 1'b1, 5'd6);
        expect_redirect("R6 b float", HRST);
        issue(2'b00, 32'd1, 8'h01, 1'b1, 32'd2, 8'h01, 1'b1, 5'd6);
        expect_redirect("R5 R6 both float same tag", HRST);
        @(negedge clk);
        check("R6 pulse ends", 64'(redirect_valid), 64'd0);
    endtask

    task automatic t_handler;
        @(negedge clk);
        hdl_we = 1'b1; hdl_wdata = 32'h0000_4440;
        @(negedge clk);
        hdl_we = 1'b0;
        check("R7 hdl_value", 64'(hdl_value), 64'h4440);
        issue(2'b00, 32'd1, 8'h02, 1'b0, 32'd1, 8'h03, 1'b0, 5'd0);
        expect_redirect("R7 new target", 32'h0000_4440);
        // write and mismatch in the same cycle: old target used
        @(negedge clk);
        hdl_we = 1'b1; hdl_wdata = 32'h0000_8880;
        issue_valid = 1'b1; issue_op = 2'b01;
        a_tag = 8'h02; b_tag = 8'h09; a_fi = 1'b0; b_fi = 1'b0;
        @(negedge clk);
        issue_valid = 1'b0; hdl_we = 1'b0;
        expect_redirect("R7 same-cycle old target", 32'h0000_4440);
        check("R7 hdl after same-cycle write", 64'(hdl_value), 64'h8880);
    endtask

    task automatic t_reserved;
        issue(2'b11, 32'd1, 8'h01, 1'b0, 32'd1, 8'h01, 1'b0, 5'd2);
        check("R8 reserved match wb", 64'(wb_valid), 64'd0);
        check("R8 reserved match redirect", 64'(redirect_valid), 64'd0);
        issue(2'b11, 32'd1, 8'h01, 1'b0, 32'd1, 8'h02, 1'b1, 5'd2);
        check("R8 reserved mismatch wb", 64'(wb_valid), 64'd0);
        check("R8 reserved mismatch redirect", 64'(redirect_valid), 64'd0);
    endtask

    task automatic t_idle;
        issue(2'b00, 32'd3, 8'h44, 1'b0, 32'd4, 8'h44, 1'b0, 5'd8);
        expect_wb("R5 before idle", 32'd7, 8'h44, 5'd8);
        a_tag = 8'h01; b_tag = 8'h02;
        @(negedge clk);
        check("R9 idle wb", 64'(wb_valid), 64'd0);
        check("R9 idle redirect", 64'(redirect_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_mul();
        t_mismatch();
        t_handler();
        t_reserved();
        t_idle();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule